// File: doc/BRIEF.md
# Receive FIFO Flow Throttle

This block watches the fill level of a UART receive FIFO and throttles the remote sender. It uses a high mark and a low mark with hysteresis between them. Once the level reaches the high mark, the flow is marked stopped. The flow is marked running again only when the level drops below the low mark. Levels between the two marks never cause a change.

In in-band mode, each change of state raises a request to the serial transmitter to insert one stop character or one resume character. The request stays up until the transmitter answers with a one-cycle done pulse. In out-of-band mode, the active-low request-to-send and data-terminal-ready lines follow the same stopped state. Both modes share the same pair of marks.

The marks come from two programmable registers when enhanced levels are enabled. Otherwise they come from a two-bit fixed-level select.

Top module: `rx_flow_throttle`

## Requirements
- R1: After reset the flow is running, `rts_n` and `dtr_n` are low, and `req_valid` is low.
- R2: With in-band mode on, the cycle after the fill level first reaches the high mark (level >= high), `req_valid` is high and `req_char` holds the stop character (0x13 by default).
- R3: While stopped, the cycle after the fill level falls below the low mark (level < low), `req_valid` is high and `req_char` holds the resume character (0x11 by default).
- R4: Only one request is raised per crossing. Fill levels between the marks, or levels that stay beyond the mark already crossed, raise no further request.
- R5: A raised request keeps `req_valid` high, with its character, until `tx_done` is sampled high. `req_valid` is low on the following cycle unless a new crossing occurs in that same cycle.
- R6: If a new crossing occurs while a request is still pending, the new character replaces the pending one and `req_valid` stays high.
- R7: With enhanced levels on and a low mark of zero, `cfg_err` is high. While it holds, no resume request is raised and the handshake lines stay deasserted. A stop request is still raised.
- R8: With `rts_auto_en` high, `rts_n` is high exactly while the flow is stopped. With `rts_auto_en` low, `rts_n` stays low.
- R9: With `dtr_mode` equal to 2'b01, `dtr_n` is high exactly while the flow is stopped. For any other value of `dtr_mode`, `dtr_n` stays low.
- R10: With `enh_en` low, the high mark is (`fix_sel`+1)*DEPTH/4 and the low mark is half of that. `thr_hi` and `thr_lo` are ignored and `cfg_err` stays low.
- R11: With `inband_en` low, no request is raised, but the stopped state and the handshake lines still track the marks.
- R12: With a low mark of 64 and a high mark of 100, the stop character is requested at 100 stored characters and the resume character at 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_lvl | input | LVL_W | Current receive FIFO fill level |
| thr_hi | input | LVL_W | Programmable high mark |
| thr_lo | input | LVL_W | Programmable low mark |
| enh_en | input | 1 | Use programmable marks instead of fixed levels |
| fix_sel | input | 2 | Fixed-level select, used when enh_en is low |
| inband_en | input | 1 | Enable stop/resume character requests |
| rts_auto_en | input | 1 | Enable automatic request-to-send control |
| dtr_mode | input | 2 | Data-terminal-ready control select (2'b01 enables) |
| tx_done | input | 1 | Transmitter has taken the pending character |
| req_valid | output | 1 | A character request is pending |
| req_char | output | CHR_W | Character to insert (stop or resume) |
| rts_n | output | 1 | Active-low request-to-send |
| dtr_n | output | 1 | Active-low data-terminal-ready |
| cfg_err | output | 1 | Low mark of zero in enhanced mode |

## Verification
The assertions assume that `tx_done` is pulsed only while a request is pending. They also assume that the mode inputs change only between comparisons, never in mid-handshake. The bench respects both. Its acknowledge monitor raises `tx_done` for exactly one cycle after it consumes a pending request. Levels and configuration are changed only on falling edges, and the bench then waits long enough for every request to be acknowledged before it changes the next setting. The only exception is the pending-hold test: there the monitor's acknowledge is switched off on purpose, so a request can be held pending and then replaced.

// File: rtl/rx_flow_throttle.sv
module rx_flow_throttle #(
  parameter int LVL_W = 8,
  parameter int DEPTH = 128,
  parameter int CHR_W = 8,
  parameter logic [CHR_W-1:0] XOFF_CHR = 8'h13,
  parameter logic [CHR_W-1:0] XON_CHR  = 8'h11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fill_lvl,
  input  logic [LVL_W-1:0] thr_hi,
  input  logic [LVL_W-1:0] thr_lo,
  input  logic             enh_en,
  input  logic [1:0]       fix_sel,
  input  logic             inband_en,
  input  logic             rts_auto_en,
  input  logic [1:0]       dtr_mode,
  input  logic             tx_done,
  output logic             req_valid,
  output logic [CHR_W-1:0] req_char,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             cfg_err
);
  localparam int QTR = DEPTH / 4;

  logic [LVL_W:0]   fix_hi;
  logic [LVL_W-1:0] hi_lvl, lo_lvl;
  logic             stopped, go_stop, go_run;

  assign fix_hi  = (LVL_W+1)'((32'(fix_sel) + 32'd1) * QTR);
  assign hi_lvl  = enh_en ? thr_hi : fix_hi[LVL_W-1:0];
  assign lo_lvl  = enh_en ? thr_lo : fix_hi[LVL_W:1];
  assign cfg_err = enh_en && (thr_lo == '0);

  assign go_stop = !stopped && (fill_lvl >= hi_lvl);
  assign go_run  = stopped && (fill_lvl < lo_lvl) && !cfg_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped   <= 1'b0;
      req_valid <= 1'b0;
      req_char  <= '0;
    end else begin
      if (go_stop)     stopped <= 1'b1;
      else if (go_run) stopped <= 1'b0;

      if ((go_stop || go_run) && inband_en) begin
        req_valid <= 1'b1;
        req_char  <= go_stop ? XOFF_CHR : XON_CHR;
      end else if (tx_done) begin
        req_valid <= 1'b0;
      end
    end
  end

  assign rts_n = rts_auto_en && stopped;
  assign dtr_n = (dtr_mode == 2'b01) && stopped;
endmodule

// File: rtl/rx_flow_throttle_chk.sv
module rx_flow_throttle_chk #(
  parameter int CHR_W = 8,
  parameter logic [CHR_W-1:0] XOFF_CHR = 8'h13,
  parameter logic [CHR_W-1:0] XON_CHR  = 8'h11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inband_en,
  input logic             rts_auto_en,
  input logic [1:0]       dtr_mode,
  input logic             tx_done,
  input logic             req_valid,
  input logic [CHR_W-1:0] req_char,
  input logic             rts_n,
  input logic             dtr_n,
  input logic             cfg_err
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!req_valid && !rts_n && !dtr_n));

  a_r5_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tx_done) |=> req_valid);

  a_r2_legal_char: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_char == XOFF_CHR || req_char == XON_CHR));

  a_r7_no_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && rts_n) |=> (rts_n || !rts_auto_en));

  a_r8_rts_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_auto_en |-> !rts_n);

  a_r9_dtr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (dtr_mode != 2'b01) |-> !dtr_n);

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!inband_en && !req_valid) |=> !req_valid);
endmodule

bind rx_flow_throttle rx_flow_throttle_chk #(
  .CHR_W(CHR_W), .XOFF_CHR(XOFF_CHR), .XON_CHR(XON_CHR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inband_en(inband_en), .rts_auto_en(rts_auto_en),
  .dtr_mode(dtr_mode), .tx_done(tx_done), .req_valid(req_valid),
  .req_char(req_char), .rts_n(rts_n), .dtr_n(dtr_n), .cfg_err(cfg_err)
);

// File: tb/test_rx_flow_throttle.sv
`timescale 1ns/1ps
module test_rx_flow_throttle;
  localparam int XOFF = 8'h13;
  localparam int XON  = 8'h11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] fill_lvl = '0, thr_hi = 8'd100, thr_lo = 8'd64;
  logic       enh_en = 1'b1, inband_en = 1'b1, rts_auto_en = 1'b1;
  logic [1:0] fix_sel = 2'd0, dtr_mode = 2'b01;
  logic       tx_done = 1'b0;
  logic       req_valid, rts_n, dtr_n, cfg_err;
  logic [7:0] req_char;

  int    checks = 0, fails = 0;
  bit    auto_ack = 1'b1;
  int    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  rx_flow_throttle i_rx_flow_throttle (
    .clk(clk), .rst_n(rst_n), .fill_lvl(fill_lvl), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .enh_en(enh_en), .fix_sel(fix_sel), .inband_en(inband_en),
    .rts_auto_en(rts_auto_en), .dtr_mode(dtr_mode), .tx_done(tx_done),
    .req_valid(req_valid), .req_char(req_char), .rts_n(rts_n), .dtr_n(dtr_n),
    .cfg_err(cfg_err)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_lvl(int v, int xp, string tag);
    if (xp >= 0) begin
      exp_q.push_back(xp);
      tag_q.push_back(tag);
    end
    @(negedge clk) fill_lvl = 8'(v);
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      tx_done = 1'b0;
      if (auto_ack && req_valid) begin
        if (exp_q.size() == 0) begin
          chk("R4 unexpected request", int'(req_char), -1);
        end else begin
          chk(tag_q.pop_front(), int'(req_char), exp_q.pop_front());
        end
        tx_done = 1'b1;
      end
    end
  end

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 rts_n", int'(rts_n), 0);
    chk("R1 dtr_n", int'(dtr_n), 0);

    drive_lvl(99, -1, "");
    chk("R12 no stop at 99", int'(rts_n), 0);
    drive_lvl(100, XOFF, "R2 R12 stop at 100");
    chk("R8 rts_n stopped", int'(rts_n), 1);
    chk("R9 dtr_n stopped", int'(dtr_n), 1);
    drive_lvl(80, -1, "");
    drive_lvl(64, -1, "");
    chk("R4 held between marks", int'(rts_n), 1);
    drive_lvl(63, XON, "R3 R12 resume at 63");
    chk("R8 rts_n running", int'(rts_n), 0);
    chk("R9 dtr_n running", int'(dtr_n), 0);

    drive_lvl(110, XOFF, "R4 second stop");
    drive_lvl(120, -1, "");
    drive_lvl(50, XON, "R4 second resume");

    auto_ack = 1'b0;
    drive_lvl(100, -1, "");
    repeat (5) @(negedge clk);
    chk("R5 still pending", int'(req_valid), 1);
    chk("R5 pending char", int'(req_char), XOFF);
    drive_lvl(10, -1, "");
    chk("R6 replaced char", int'(req_char), XON);
    chk("R6 still pending", int'(req_valid), 1);
    exp_q.push_back(XON);
    tag_q.push_back("R6 replaced delivered");
    auto_ack = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 cleared after done", int'(req_valid), 0);

    thr_lo = 8'd0;
    drive_lvl(100, XOFF, "R7 stop with bad low mark");
    chk("R7 cfg_err", int'(cfg_err), 1);
    drive_lvl(0, -1, "");
    chk("R7 rts_n held", int'(rts_n), 1);
    chk("R7 no resume", int'(req_valid), 0);
    exp_q.push_back(XON);
    tag_q.push_back("R7 resume after fix");
    @(negedge clk) thr_lo = 8'd5;
    repeat (4) @(negedge clk);
    chk("R7 cfg_err clear", int'(cfg_err), 0);
    chk("R7 rts_n released", int'(rts_n), 0);

    inband_en = 1'b0;
    drive_lvl(100, -1, "");
    chk("R11 rts_n tracks", int'(rts_n), 1);
    chk("R11 no request", int'(req_valid), 0);
    drive_lvl(0, -1, "");
    chk("R11 rts_n back", int'(rts_n), 0);

    dtr_mode = 2'b10;
    rts_auto_en = 1'b0;
    drive_lvl(100, -1, "");
    chk("R9 dtr_n off mode", int'(dtr_n), 0);
    chk("R8 rts_n disabled", int'(rts_n), 0);
    drive_lvl(0, -1, "");

    enh_en = 1'b0;
    fix_sel = 2'd1;
    inband_en = 1'b1;
    rts_auto_en = 1'b1;
    thr_lo = 8'd0;
    thr_hi = 8'd100;
    @(negedge clk);
    chk("R10 cfg_err ignored", int'(cfg_err), 0);
    drive_lvl(63, -1, "");
    chk("R10 below fixed high", int'(rts_n), 0);
    drive_lvl(64, XOFF, "R10 fixed high 64");
    drive_lvl(40, -1, "");
    chk("R10 above fixed low", int'(rts_n), 1);
    drive_lvl(31, XON, "R10 fixed low 32");

    repeat (4) @(negedge clk);
    chk("R4 queue drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule